// File: doc/BRIEF.md
# Dual Four-Mode Up-Counting Timer

This block holds two up-counting timer/counters that share one mode byte and one control byte. Each timer can count either pulses of a free-running machine-cycle tick or falling edges seen on its own external count pin. Each timer can also be gated by an external level pin, so that it accumulates only while that pin is high. Gated counting is used to measure the width of a pulse on the gate pin.

Software loads the mode byte, the control byte and the four count bytes through a simple one-cycle write port. All six registers are visible on output pins at all times. Each timer has four counting shapes: a 13-bit counter made of a 5-bit prescaler under an 8-bit high byte, a full 16-bit counter, an 8-bit counter that reloads from its high byte, and a split shape in which timer 0 becomes two independent 8-bit counters. A timer raises its overflow flag when its count wraps. Software clears a flag by writing the control byte. Interrupt routing is left to the surrounding logic.

The write port and the pins are plain control signals, and the block has no back-pressure. A write is taken in the cycle in which `wr_en_i` is high.

Top module: `twin_cycle_timer`

## Requirements
- R1: After reset, the mode byte, the control byte and all four count bytes read 0x00.
- R2: Writes use 3-bit addresses: 0 is the mode byte, 1 is the control byte, 2 and 3 are timer 0 low and high, and 4 and 5 are timer 1 low and high. Addresses 6 and 7 change nothing. A written count byte shows the new value after the next clock edge. A write to either count byte of a timer stops that timer from counting, and from overflowing, in that cycle.
- R3: In the mode byte, bits 3:0 configure timer 0 and bits 7:4 configure timer 1. Within each nibble, bit 3 is gate enable, bit 2 is the source select (1 means the external pin), and bits 1:0 are the shape: 00 is 13-bit, 01 is 16-bit, 10 is reload and 11 is split. The mode byte reads back exactly as written.
- R4: In the control byte, bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Bits 3:0 always read 0. A write to the control byte loads bits 7:4. If an overflow occurs in the same cycle as that write, the affected flag still ends up set.
- R5: A timer advances only while its run bit is 1. When its gate enable is 1, it also needs its gate pin to be high. The gate pin passes through a two-flop synchronizer, so a level seen at edge k first controls counting at edge k+2.
- R6: With source select 0, a timer advances once for every cycle in which `tick_i` is high. With source select 1, it advances once for every high-to-low transition of its count pin. That transition passes through a two-flop synchronizer and an edge flop, so the count changes at the third rising edge that samples the pin low.
- R7: In the 13-bit shape, low bits 4:0 act as a prescaler and low bits 7:5 never change by counting. A prescaler wrap increments the high byte. The flag is set when the prescaler is 0x1F and the high byte is 0xFF when the timer advances.
- R8: In the 16-bit shape, {high, low} increments as one value, and the flag is set when the count goes from 0xFFFF to 0x0000.
- R9: In the reload shape, when the low byte advances from 0xFF it takes the value of the high byte and sets the flag. The high byte itself never changes by counting.
- R10: When timer 0 is in the split shape:
  - Its low byte counts under timer 0's own run, gate and source settings, and sets flag 0 when it wraps.
  - Its high byte counts `tick_i` cycles whenever run 1 is set, and sets flag 1 when it wraps.
  - Timer 1 keeps counting, but its wraps no longer set flag 1.
- R11: Timer 1 set to the split shape holds both of its count bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick, one clock wide per tick |
| cnt_pin_i | input | 2 | External count pins, bit i belongs to timer i |
| gate_pin_i | input | 2 | External gate pins, bit i belongs to timer i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| mode_o | output | 8 | Mode byte |
| ctrl_o | output | 8 | Control byte (flags and run bits) |
| t0_lo_o | output | 8 | Timer 0 low count byte |
| t0_hi_o | output | 8 | Timer 0 high count byte |
| t1_lo_o | output | 8 | Timer 1 low count byte |
| t1_hi_o | output | 8 | Timer 1 high count byte |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a hardware overflow and a software write to the control byte. The bench provokes it by keeping timer 0 in the reload shape with both bytes at 0xFF, so that it wraps on every tick, and then writing a cleared flag while it runs; flag 0 must still read 1 afterwards. The second pair is a count-byte write and an increment: the written value must appear unchanged, with no carry and no flag. A behavioural model tracks every register on every clock and judges both cases.

// File: rtl/twt_pkg.sv
package twt_pkg;

  typedef enum logic [1:0] {
    SHAPE_PRESCALE = 2'b00,
    SHAPE_FULL     = 2'b01,
    SHAPE_RELOAD   = 2'b10,
    SHAPE_SPLIT    = 2'b11
  } shape_e;

  localparam logic [2:0] ADR_MODE  = 3'd0;
  localparam logic [2:0] ADR_CTRL  = 3'd1;
  localparam logic [2:0] ADR_T0_LO = 3'd2;
  localparam logic [2:0] ADR_T0_HI = 3'd3;
  localparam logic [2:0] ADR_T1_LO = 3'd4;
  localparam logic [2:0] ADR_T1_HI = 3'd5;

  localparam int BIT_RUN0  = 4;
  localparam int BIT_FLAG0 = 5;
  localparam int BIT_RUN1  = 6;
  localparam int BIT_FLAG1 = 7;

endpackage

// File: rtl/twt_pin_sync.sv
module twt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], pin_i};
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/twt_core.sv
module twt_core
  import twt_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  shape_e       shape_i,
  input  logic         inc_lo_i,
  input  logic         inc_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_o,
  output logic         ovf_hi_o
);
  localparam logic [PRE_W-1:0] PRE_TOP = '1;

  logic [W-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (shape_i)
      SHAPE_PRESCALE: if (inc_lo_i) begin
        lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
        if (lo_q[PRE_W-1:0] == PRE_TOP) begin
          hi_n  = hi_q + 1'b1;
          ovf_o = &hi_q;
        end
      end
      SHAPE_FULL: if (inc_lo_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
        ovf_o        = &{hi_q, lo_q};
      end
      SHAPE_RELOAD: if (inc_lo_i) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      SHAPE_SPLIT: if (SPLIT_OK) begin
        if (inc_lo_i) begin
          lo_n  = lo_q + 1'b1;
          ovf_o = &lo_q;
        end
        if (inc_hi_i) begin
          hi_n     = hi_q + 1'b1;
          ovf_hi_o = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i || wr_hi_i) begin
      lo_n     = wr_lo_i ? wr_data_i : lo_q;
      hi_n     = wr_hi_i ? wr_data_i : hi_q;
      ovf_o    = 1'b0;
      ovf_hi_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/twin_cycle_timer.sv
module twin_cycle_timer
  import twt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] t0_lo_o,
  output logic [BYTE_W-1:0] t0_hi_o,
  output logic [BYTE_W-1:0] t1_lo_o,
  output logic [BYTE_W-1:0] t1_hi_o
);
  localparam int NT = 2;
  localparam int NIB = BYTE_W / 2;

  logic [BYTE_W-1:0] mode_q, ctrl_q, ctrl_n;
  logic [NT-1:0] cnt_lvl, cnt_prev_q, cnt_fall, gate_lvl;
  logic [NT-1:0] inc_lo, inc_hi, core_ovf, core_ovf_hi, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo_v [NT];
  logic [BYTE_W-1:0] hi_v [NT];
  logic t0_split, set_f0, set_f1, t0_ovf, t0_hi_ovf;

  wire wr_mode = wr_en_i && (wr_addr_i == ADR_MODE);
  wire wr_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);

  assign t0_split = (mode_q[1:0] == SHAPE_SPLIT);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic [NIB-1:0] cfg;
    logic run, enabled, event_hit;

    twt_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i[i]), .level_o(cnt_lvl[i]));
    twt_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i[i]), .level_o(gate_lvl[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_prev_q[i] <= 1'b0;
      else        cnt_prev_q[i] <= cnt_lvl[i];
    end
    assign cnt_fall[i] = cnt_prev_q[i] & ~cnt_lvl[i];

    assign cfg       = mode_q[NIB*i +: NIB];
    assign run       = ctrl_q[BIT_RUN0 + 2*i];
    assign enabled   = run & (~cfg[3] | gate_lvl[i]);
    assign event_hit = cfg[2] ? cnt_fall[i] : tick_i;
    assign inc_lo[i] = enabled & event_hit;
    assign inc_hi[i] = (i == 0) ? (ctrl_q[BIT_RUN1] & tick_i) : 1'b0;
    assign wr_lo[i]  = wr_en_i && (wr_addr_i == ADR_T0_LO + 3'(2*i));
    assign wr_hi[i]  = wr_en_i && (wr_addr_i == ADR_T0_HI + 3'(2*i));

    twt_core #(.W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(i == 0)) u_core (
      .clk(clk), .rst_n(rst_n), .shape_i(shape_e'(cfg[1:0])),
      .inc_lo_i(inc_lo[i]), .inc_hi_i(inc_hi[i]),
      .wr_lo_i(wr_lo[i]), .wr_hi_i(wr_hi[i]), .wr_data_i(wr_data_i),
      .lo_o(lo_v[i]), .hi_o(hi_v[i]),
      .ovf_o(core_ovf[i]), .ovf_hi_o(core_ovf_hi[i]));
  end

  assign t0_ovf    = core_ovf[0];
  assign t0_hi_ovf = core_ovf_hi[0];
  assign set_f0    = core_ovf[0];
  assign set_f1    = t0_split ? core_ovf_hi[0] : (core_ovf[1] | core_ovf_hi[1]);

  always_comb begin
    ctrl_n = wr_ctrl ? {wr_data_i[BYTE_W-1:NIB], {NIB{1'b0}}} : ctrl_q;
    if (set_f0) ctrl_n[BIT_FLAG0] = 1'b1;
    if (set_f1) ctrl_n[BIT_FLAG1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data_i;
      ctrl_q <= ctrl_n;
    end
  end

  assign mode_o  = mode_q;
  assign ctrl_o  = ctrl_q;
  assign t0_lo_o = lo_v[0];
  assign t0_hi_o = hi_v[0];
  assign t1_lo_o = lo_v[1];
  assign t1_hi_o = hi_v[1];
endmodule

// File: rtl/twt_chk.sv
module twt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] mode_o,
  input logic [7:0] ctrl_o,
  input logic [7:0] t0_lo_o,
  input logic [7:0] t1_lo_o,
  input logic [7:0] t1_hi_o,
  input logic       t0_ovf,
  input logic       t0_hi_ovf
);
  wire wr_ctl = wr_en_i && (wr_addr_i == 3'd1);
  wire wr_t0  = wr_en_i && (wr_addr_i == 3'd2 || wr_addr_i == 3'd3);
  wire wr_t1  = wr_en_i && (wr_addr_i == 3'd4 || wr_addr_i == 3'd5);

  p_ovf_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t0_ovf |=> ctrl_o[5]);

  p_split_hi_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1:0] == 2'b11 && t0_hi_ovf) |=> ctrl_o[7]);

  p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 3'd2) |=> (t0_lo_o == $past(wr_data_i)));

  p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[4] && !wr_t0) |=> $stable(t0_lo_o));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[5] && !wr_ctl) |=> ctrl_o[5]);

  p_t1_split_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[5:4] == 2'b11 && !wr_t1) |=> ($stable(t1_lo_o) && $stable(t1_hi_o)));

  p_ctrl_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[3:0] == 4'h0);
endmodule

bind twin_cycle_timer twt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .mode_o(mode_o), .ctrl_o(ctrl_o),
  .t0_lo_o(t0_lo_o), .t1_lo_o(t1_lo_o), .t1_hi_o(t1_hi_o),
  .t0_ovf(t0_ovf), .t0_hi_ovf(t0_hi_ovf));

// File: tb/twin_cycle_timer_tb.sv
`timescale 1ns/1ps
module twin_cycle_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] cpin = 2'b11;
  logic [1:0] gpin = 2'b00;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] mode_o, ctrl_o, t0_lo, t0_hi, t1_lo, t1_hi;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  twin_cycle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_pin_i(cpin), .gate_pin_i(gpin),
    .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
    .mode_o(mode_o), .ctrl_o(ctrl_o), .t0_lo_o(t0_lo), .t0_hi_o(t0_hi),
    .t1_lo_o(t1_lo), .t1_hi_o(t1_hi));

  // behavioural reference model
  int m_lo[2], m_hi[2];
  int m_mode, m_ctrl;
  bit c1[2], c2[2], c3[2], g1[2], g2[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ctrl = 0;
      foreach (m_lo[t]) begin
        m_lo[t] = 0; m_hi[t] = 0;
        c1[t] = 0; c2[t] = 0; c3[t] = 0; g1[t] = 0; g2[t] = 0;
      end
    end else begin
      bit fall[2], glev[2], of[2], ofh;
      int nc;
      ofh = 0;
      for (int t = 0; t < 2; t++) begin
        fall[t] = c3[t] && !c2[t];
        glev[t] = g2[t];
        c3[t] = c2[t]; c2[t] = c1[t]; c1[t] = cpin[t];
        g2[t] = g1[t]; g1[t] = gpin[t];
      end
      for (int t = 0; t < 2; t++) begin
        int shp, v;
        bit gt, src, run, inc, hit;
        shp = (m_mode >> (4*t)) & 3;
        src = ((m_mode >> (4*t + 2)) & 1) != 0;
        gt  = ((m_mode >> (4*t + 3)) & 1) != 0;
        run = ((m_ctrl >> (4 + 2*t)) & 1) != 0;
        inc = run && (!gt || glev[t]) && (src ? fall[t] : tick);
        hit = wr_en && (addr == 3'(2 + 2*t) || addr == 3'(3 + 2*t));
        of[t] = 0;
        if (hit) begin
          if (addr == 3'(2 + 2*t)) m_lo[t] = wdata; else m_hi[t] = wdata;
        end else begin
          case (shp)
            0: if (inc) begin
              v = m_hi[t] * 32 + (m_lo[t] % 32) + 1;
              if (v == 8192) begin v = 0; of[t] = 1; end
              m_hi[t] = v / 32;
              m_lo[t] = (m_lo[t] / 32) * 32 + (v % 32);
            end
            1: if (inc) begin
              v = m_hi[t] * 256 + m_lo[t] + 1;
              if (v == 65536) begin v = 0; of[t] = 1; end
              m_hi[t] = v / 256; m_lo[t] = v % 256;
            end
            2: if (inc) begin
              if (m_lo[t] == 255) begin m_lo[t] = m_hi[t]; of[t] = 1; end
              else m_lo[t] = m_lo[t] + 1;
            end
            default: if (t == 0) begin
              if (inc) begin
                m_lo[0] = (m_lo[0] + 1) % 256;
                if (m_lo[0] == 0) of[0] = 1;
              end
              if (((m_ctrl >> 6) & 1) != 0 && tick) begin
                m_hi[0] = (m_hi[0] + 1) % 256;
                if (m_hi[0] == 0) ofh = 1;
              end
            end
          endcase
        end
      end
      nc = (wr_en && addr == 3'd1) ? (int'(wdata) & 'hF0) : m_ctrl;
      if (of[0]) nc = nc | 'h20;
      if (((m_mode & 3) == 3) ? ofh : of[1]) nc = nc | 'h80;
      if (wr_en && addr == 3'd0) m_mode = wdata;
      m_ctrl = nc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (mode_o != 8'(m_mode) || ctrl_o != 8'(m_ctrl) ||
          t0_lo != 8'(m_lo[0]) || t0_hi != 8'(m_hi[0]) ||
          t1_lo != 8'(m_lo[1]) || t1_hi != 8'(m_hi[1])) begin
        errors++;
        $display("FAIL %s model: act m=%h c=%h t0=%h%h t1=%h%h exp m=%h c=%h t0=%h%h t1=%h%h",
          cur_req, mode_o, ctrl_o, t0_hi, t0_lo, t1_hi, t1_lo,
          8'(m_mode), 8'(m_ctrl), 8'(m_hi[0]), 8'(m_lo[0]), 8'(m_hi[1]), 8'(m_lo[1]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp < 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    cur_req = "R1";
    chk("R1", {mode_o, ctrl_o, t0_lo, t0_hi, t1_lo, t1_hi}, 0);

    cur_req = "R2";
    wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    chk("R2", {t0_hi, t0_lo, t1_hi, t1_lo}, 32'h34127856);
    chk("R2 unmapped", {mode_o, ctrl_o}, 0);

    cur_req = "R3";
    wr(3'd0, 8'hA5);
    chk("R3", mode_o, 8'hA5);

    cur_req = "R8";
    wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    tick = 1'b1;
    wr(3'd1, 8'h10);
    wait_cyc(24);
    chk("R8 flag", ctrl_o[5], 1);
    chk("R8 hi", t0_hi, 0);
    wr(3'd1, 8'h00);
    chk("R4 clear", ctrl_o, 0);

    cur_req = "R7";
    wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    wait_cyc(5);
    chk("R7 upper", t0_lo & 8'hE0, 8'hE0);
    chk("R7 flag", {ctrl_o[5], t0_hi}, 9'h100);
    wr(3'd1, 8'h00);

    cur_req = "R9";
    wr(3'd0, 8'h20); wr(3'd5, 8'hF0); wr(3'd4, 8'hFC);
    wr(3'd1, 8'h40);
    wait_cyc(12);
    chk("R9 hi", t1_hi, 8'hF0);
    chk("R9 flag", ctrl_o[7], 1);
    wr(3'd1, 8'h00);

    cur_req = "R6";
    tick = 1'b0;
    wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h40);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); cpin[1] = 1'b0;
      wait_cyc(2); cpin[1] = 1'b1;
      wait_cyc(1);
    end
    wait_cyc(4);
    chk("R6 edges", t1_lo, 5);
    wr(3'd1, 8'h00);

    cur_req = "R5";
    tick = 1'b1;
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    wait_cyc(10);
    chk("R5 gate low", t0_lo, 0);
    gpin[0] = 1'b1;
    wait_cyc(6);
    gpin[0] = 1'b0;
    wait_cyc(5);
    chk("R5 gated width", t0_lo, 6);
    wr(3'd1, 8'h00);
    wait_cyc(3);
    chk("R5 stopped", t0_lo, 6);

    cur_req = "R10";
    wr(3'd0, 8'h13); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h50);
    wait_cyc(5);
    chk("R10 t1 wrap no flag", ctrl_o[7], 0);
    wr(3'd3, 8'hFF);
    wait_cyc(2);
    chk("R10 split hi flag", ctrl_o[7], 1);
    wr(3'd2, 8'hFE);
    wait_cyc(3);
    chk("R10 split lo flag", ctrl_o[5], 1);
    wr(3'd1, 8'h00);

    cur_req = "R11";
    wr(3'd0, 8'h30); wr(3'd4, 8'h55); wr(3'd5, 8'hAA);
    wr(3'd1, 8'h40);
    wait_cyc(10);
    chk("R11 hold", {t1_hi, t1_lo}, 16'hAA55);
    wr(3'd1, 8'h00);

    cur_req = "R4";
    wr(3'd0, 8'h02); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    wait_cyc(3);
    wr(3'd1, 8'h10);
    chk("R4 set beats clear", ctrl_o[5], 1);
    tick = 1'b0;
    wait_cyc(1);
    wr(3'd1, 8'h10);
    chk("R4 clear when idle", ctrl_o, 8'h10);
    wr(3'd1, 8'h0F);
    chk("R4 low bits zero", ctrl_o, 0);

    wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule